// File: doc/BRIEF.md
# Port Direction Instruction Unit

This block carries out the direction-setting instruction for a small controller with three general I/O ports. The instruction decoder raises `exec_en` for one cycle. With it come the three selector bits from the low end of the opcode and the working-register value that holds the new direction pattern. A direction bit of 1 makes the pin an input. A direction bit of 0 lets the pin drive the value held in its port latch.

A five-state controller handles each instruction in three clock edges:

- `S_IDLE` captures the selector and the value. Its only transition is `S_IDLE -> S_CHECK`, taken on `exec_en`.
- `S_CHECK` decodes the selector and compares the value against the selected direction register. It then takes exactly one of three transitions: `S_CHECK -> S_TRAP` for a selector outside 5..7, `S_CHECK -> S_SKIP` when the value equals the current direction, and `S_CHECK -> S_APPLY` otherwise.
- `S_APPLY`, `S_SKIP` and `S_TRAP` each return to `S_IDLE` on the next edge.

In `S_APPLY` the selected port slice loads its direction register, refreshes its driven pin value and pulses its change strobe. In `S_TRAP` the illegal-instruction flag pulses. In `S_SKIP` nothing changes.

Every path takes the same number of cycles. An instruction is accepted only in `S_IDLE`.

Top module: `pdir_ctrl`

## Requirements
- R1: While reset is low, and directly after it, every direction register holds 8'hFF, every pin value, output enable, change strobe and the illegal flag are 0.
- R2: If `exec_en` is sampled high at a rising edge k in idle, selector 5 targets port A, 6 targets port B and 7 targets port C. The selected direction register shows the new value after edge k+2, and the other two ports do not change.
- R3: If the new value equals the selected port's current direction, no direction, pin value, strobe or illegal flag changes.
- R4: On an update, the pin value of the port becomes its latch value (sampled at edge k+2) ANDed with the inverted new direction.
- R5: For port A, bits 7:4 of the pin value are always 0.
- R6: Each output-enable bit is the inverse of the corresponding direction bit at all times.
- R7: The change strobe of a port (bit 0 = A, 1 = B, 2 = C) is high for exactly the one cycle after edge k+2 when that port is updated. It is never high for a port that was not updated.
- R8: A selector of 0 to 4 raises `illegal_op` for exactly the one cycle after edge k+2, and leaves all directions and pin values unchanged.
- R9: `exec_en` sampled high at edges k+1 and k+2 is ignored. The next instruction can be accepted at edge k+3.
- R10: A pin value does not follow a change of its latch unless the port's direction is updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_en | input | 1 | One-cycle request to execute the instruction |
| op_sel | input | 3 | Low opcode bits selecting the port |
| w_val | input | 8 | New direction pattern |
| latch_a | input | 8 | Port A output latch |
| latch_b | input | 8 | Port B output latch |
| latch_c | input | 8 | Port C output latch |
| dir_a | output | 8 | Port A direction register (1 = input) |
| dir_b | output | 8 | Port B direction register |
| dir_c | output | 8 | Port C direction register |
| pin_a | output | 8 | Port A driven pin value, bits 7:4 zero |
| pin_b | output | 8 | Port B driven pin value |
| pin_c | output | 8 | Port C driven pin value |
| oe_a | output | 8 | Port A output enables |
| oe_b | output | 8 | Port B output enables |
| oe_c | output | 8 | Port C output enables |
| dir_chg | output | 3 | Per-port change strobe, bit 0 = A |
| illegal_op | output | 1 | Illegal selector pulse |

## Verification
Two things can fall in the same cycle: an update or trap of one instruction in `S_APPLY`/`S_TRAP`, and the arrival of the next `exec_en`. The bench provokes this by holding `exec_en` high across the two busy edges with a different selector and value. A behavioural model compares every output on every clock. It also checks directly that the second port kept its direction and that only one strobe fired. A latch change that coincides with no direction update is judged in the same way, against the frozen pin value.

// File: rtl/pdir_pkg.sv
package pdir_pkg;
    localparam int NPORT    = 3;
    localparam int DATA_W   = 8;
    localparam int SEL_W    = 3;
    localparam int SEL_BASE = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_APPLY,
        S_SKIP,
        S_TRAP
    } pdir_state_e;
endpackage

// File: rtl/pdir_sel_decode.sv
module pdir_sel_decode
    import pdir_pkg::*;
#(
    parameter int N_PORT = NPORT,
    parameter int SW     = SEL_W,
    parameter int BASE   = SEL_BASE
) (
    input  logic [SW-1:0]     sel,
    output logic [N_PORT-1:0] hot,
    output logic              bad
);
    for (genvar g = 0; g < N_PORT; g++) begin : g_hit
        localparam logic [SW-1:0] CODE = SW'(BASE + g);
        assign hot[g] = (sel == CODE);
    end

    assign bad = (hot == '0);

    always_comb begin
        assert ($onehot0(hot))
            else $error("selector decode produced several ports");
    end
endmodule

// File: rtl/pdir_ctrl_fsm.sv
module pdir_ctrl_fsm
    import pdir_pkg::*;
#(
    parameter int N_PORT = NPORT,
    parameter int DW     = DATA_W,
    parameter int SW     = SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic [SW-1:0]     sel_in,
    input  logic [DW-1:0]     w_in,
    input  logic [N_PORT-1:0] sel_hot,
    input  logic              sel_bad,
    input  logic [DW-1:0]     cur_dir,
    output logic [SW-1:0]     sel_q,
    output logic [DW-1:0]     w_q,
    output logic [N_PORT-1:0] wr_hot,
    output logic              illegal_q
);
    pdir_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (exec_en) state_d = S_CHECK;
            S_CHECK: begin
                if (sel_bad)              state_d = S_TRAP;
                else if (cur_dir == w_q)  state_d = S_SKIP;
                else                      state_d = S_APPLY;
            end
            S_APPLY: state_d = S_IDLE;
            S_SKIP:  state_d = S_IDLE;
            S_TRAP:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '0;
            w_q       <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= (state_q == S_TRAP);
            if (state_q == S_IDLE && exec_en) begin
                sel_q <= sel_in;
                w_q   <= w_in;
            end
        end
    end

    assign wr_hot = (state_q == S_APPLY) ? sel_hot : '0;

    // R9
    apply_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_APPLY || state_q == S_SKIP || state_q == S_TRAP) |=> state_q == S_IDLE);
    // R9
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(w_q) && $stable(sel_q));
    // R8
    trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |=> !illegal_q);
    // R8
    trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TRAP) |-> wr_hot == '0);
endmodule

// File: rtl/pdir_port_slice.sv
module pdir_port_slice
    import pdir_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int PIN_W  = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] w_new,
    input  logic [DW-1:0] latch,
    output logic [DW-1:0] dir_q,
    output logic [DW-1:0] pin_q,
    output logic [DW-1:0] oe,
    output logic          chg_q
);
    localparam logic [DW-1:0] PIN_MASK = DW'((64'd1 << PIN_W) - 64'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
            pin_q <= '0;
            chg_q <= 1'b0;
        end else begin
            chg_q <= wr_en;
            if (wr_en) begin
                dir_q <= w_new;
                pin_q <= latch & ~w_new & PIN_MASK;
            end
        end
    end

    assign oe = ~dir_q;

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q |=> !chg_q);
    // R7
    dir_move_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_q) |-> chg_q);
    // R3
    strobe_new_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q |-> dir_q != $past(dir_q));
    // R4
    pin_not_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_q & dir_q) == '0);
    // R10
    pin_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_q |-> $stable(pin_q));
endmodule

// File: rtl/pdir_ctrl.sv
module pdir_ctrl
    import pdir_pkg::*;
#(
    parameter int DW      = DATA_W,
    parameter int A_PIN_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_en,
    input  logic [2:0]    op_sel,
    input  logic [DW-1:0] w_val,
    input  logic [DW-1:0] latch_a,
    input  logic [DW-1:0] latch_b,
    input  logic [DW-1:0] latch_c,
    output logic [DW-1:0] dir_a,
    output logic [DW-1:0] dir_b,
    output logic [DW-1:0] dir_c,
    output logic [DW-1:0] pin_a,
    output logic [DW-1:0] pin_b,
    output logic [DW-1:0] pin_c,
    output logic [DW-1:0] oe_a,
    output logic [DW-1:0] oe_b,
    output logic [DW-1:0] oe_c,
    output logic [2:0]    dir_chg,
    output logic          illegal_op
);
    logic [SEL_W-1:0] sel_q;
    logic [DW-1:0]    w_q;
    logic [NPORT-1:0] sel_hot, wr_hot;
    logic             sel_bad;
    logic [DW-1:0]    cur_dir;
    logic [DW-1:0]    latch_arr [NPORT];
    logic [DW-1:0]    dir_arr   [NPORT];
    logic [DW-1:0]    pin_arr   [NPORT];
    logic [DW-1:0]    oe_arr    [NPORT];
    logic [NPORT-1:0] chg_arr;

    assign latch_arr[0] = latch_a;
    assign latch_arr[1] = latch_b;
    assign latch_arr[2] = latch_c;

    pdir_sel_decode #(.N_PORT(NPORT), .SW(SEL_W), .BASE(SEL_BASE)) i_dec (
        .sel (sel_q),
        .hot (sel_hot),
        .bad (sel_bad)
    );

    always_comb begin
        cur_dir = '0;
        for (int i = 0; i < NPORT; i++)
            if (sel_hot[i]) cur_dir = dir_arr[i];
    end

    pdir_ctrl_fsm #(.N_PORT(NPORT), .DW(DW), .SW(SEL_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_en   (exec_en),
        .sel_in    (op_sel),
        .w_in      (w_val),
        .sel_hot   (sel_hot),
        .sel_bad   (sel_bad),
        .cur_dir   (cur_dir),
        .sel_q     (sel_q),
        .w_q       (w_q),
        .wr_hot    (wr_hot),
        .illegal_q (illegal_op)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        localparam int PW = (g == 0) ? A_PIN_W : DW;
        pdir_port_slice #(.DW(DW), .PIN_W(PW)) i_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_hot[g]),
            .w_new (w_q),
            .latch (latch_arr[g]),
            .dir_q (dir_arr[g]),
            .pin_q (pin_arr[g]),
            .oe    (oe_arr[g]),
            .chg_q (chg_arr[g])
        );
    end

    assign dir_a   = dir_arr[0];
    assign dir_b   = dir_arr[1];
    assign dir_c   = dir_arr[2];
    assign pin_a   = pin_arr[0];
    assign pin_b   = pin_arr[1];
    assign pin_c   = pin_arr[2];
    assign oe_a    = oe_arr[0];
    assign oe_b    = oe_arr[1];
    assign oe_c    = oe_arr[2];
    assign dir_chg = chg_arr;

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dir_chg));
    // R8
    trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> dir_chg == '0);
    // R8
    trap_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> $stable(dir_a) && $stable(dir_b) && $stable(dir_c));
    // R5
    pin_a_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_a[DW-1:A_PIN_W] == '0);
endmodule

// File: tb/test_pdir_ctrl.sv
module test_pdir_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_en = 1'b0;
    logic [2:0] op_sel = '0;
    logic [7:0] w_val = '0;
    logic [7:0] latch_a = '0, latch_b = '0, latch_c = '0;
    logic [7:0] dir_a, dir_b, dir_c, pin_a, pin_b, pin_c, oe_a, oe_b, oe_c;
    logic [2:0] dir_chg;
    logic       illegal_op;

    int errors = 0;
    int checks = 0;
    bit armed = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pdir_ctrl i_pdir_ctrl (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel), .w_val(w_val),
        .latch_a(latch_a), .latch_b(latch_b), .latch_c(latch_c),
        .dir_a(dir_a), .dir_b(dir_b), .dir_c(dir_c),
        .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
        .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c),
        .dir_chg(dir_chg), .illegal_op(illegal_op)
    );

    // behavioural reference model
    logic [7:0] m_dir [3];
    logic [7:0] m_pin [3];
    logic [2:0] m_chg;
    logic       m_ill;
    int         phase;
    logic [2:0] c_sel;
    logic [7:0] c_w;

    function automatic logic [7:0] latch_of(int p);
        return (p == 0) ? latch_a : (p == 1) ? latch_b : latch_c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin m_dir[i] = 8'hFF; m_pin[i] = 8'h00; end
            m_chg = '0; m_ill = 1'b0; phase = 0;
        end else begin
            m_chg = '0; m_ill = 1'b0;
            if (phase == 0) begin
                if (exec_en) begin c_sel = op_sel; c_w = w_val; phase = 1; end
            end else if (phase == 1) begin
                phase = 2;
            end else begin
                if (c_sel < 3'd5) m_ill = 1'b1;
                else begin
                    int p;
                    p = int'(c_sel) - 5;
                    if (m_dir[p] != c_w) begin
                        m_dir[p] = c_w;
                        m_pin[p] = latch_of(p) & ~c_w;
                        if (p == 0) m_pin[0] = m_pin[0] & 8'h0F;
                        m_chg[p] = 1'b1;
                    end
                end
                phase = 0;
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] dut_dir(int p);
        return (p == 0) ? dir_a : (p == 1) ? dir_b : dir_c;
    endfunction
    function automatic logic [7:0] dut_pin(int p);
        return (p == 0) ? pin_a : (p == 1) ? pin_b : pin_c;
    endfunction
    function automatic logic [7:0] dut_oe(int p);
        return (p == 0) ? oe_a : (p == 1) ? oe_b : oe_c;
    endfunction

    always @(negedge clk) begin
        if (armed) begin
            for (int p = 0; p < 3; p++) begin
                chk("R2 dir", dut_dir(p), m_dir[p]);
                chk("R4 pin", dut_pin(p), m_pin[p]);
                chk("R6 oe", dut_oe(p), ~m_dir[p]);
            end
            chk("R7 strobe", {5'd0, dir_chg}, {5'd0, m_chg});
            chk("R8 illegal", {7'd0, illegal_op}, {7'd0, m_ill});
        end
    end

    // drive one instruction at a negedge and wait for completion
    task automatic issue(logic [2:0] s, logic [7:0] w);
        exec_en = 1'b1; op_sel = s; w_val = w;
        @(negedge clk);
        exec_en = 1'b0;
        @(negedge clk); @(negedge clk); // now after edge k+2
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 during and after reset
        chk("R1 dir_a", dir_a, 8'hFF);
        chk("R1 pin_b", pin_b, 8'h00);
        chk("R1 oe_c", oe_c, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        armed = 1;
        chk("R1 dir_c", dir_c, 8'hFF);
        chk("R1 strobe", {5'd0, dir_chg}, 8'h00);

        latch_a = 8'hFF; latch_b = 8'hA5; latch_c = 8'h3C;
        // R2 R4 R5 R7: port A all outputs
        issue(3'd5, 8'h00);
        chk("R2 dir_a", dir_a, 8'h00);
        chk("R5 pin_a", pin_a, 8'h0F);
        chk("R7 strobe A", {5'd0, dir_chg}, 8'h01);
        @(negedge clk);
        chk("R7 strobe drop", {5'd0, dir_chg}, 8'h00);
        // R2 R4 port B, others unchanged
        issue(3'd6, 8'h0F);
        chk("R4 pin_b", pin_b, 8'hA0);
        chk("R2 dir_c kept", dir_c, 8'hFF);
        chk("R6 oe_b", oe_b, 8'hF0);
        @(negedge clk);
        // R3 equal value on port B
        issue(3'd6, 8'h0F);
        chk("R3 no strobe", {5'd0, dir_chg}, 8'h00);
        chk("R3 pin_b", pin_b, 8'hA0);
        @(negedge clk);
        // R8 illegal selectors
        issue(3'd0, 8'h12);
        chk("R8 flag", {7'd0, illegal_op}, 8'h01);
        chk("R8 dir_a kept", dir_a, 8'h00);
        @(negedge clk);
        chk("R8 flag drop", {7'd0, illegal_op}, 8'h00);
        issue(3'd4, 8'h34);
        chk("R8 flag sel4", {7'd0, illegal_op}, 8'h01);
        @(negedge clk);
        // R10 latch change without update
        latch_b = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R10 pin_b frozen", pin_b, 8'hA0);
        // R9 exec held across busy edges with another target
        exec_en = 1'b1; op_sel = 3'd7; w_val = 8'h81;
        @(negedge clk);
        op_sel = 3'd5; w_val = 8'h55;
        @(negedge clk);
        @(negedge clk);
        exec_en = 1'b0;
        chk("R9 dir_c", dir_c, 8'h81);
        chk("R4 pin_c", pin_c, 8'h3C);
        chk("R9 dir_a kept", dir_a, 8'h00);
        chk("R9 strobe C only", {5'd0, dir_chg}, 8'h04);
        repeat (4) @(negedge clk);
        chk("R9 dir_a still", dir_a, 8'h00);
        // back to back update after idle; also R5 with new latch
        latch_a = 8'hF3;
        issue(3'd5, 8'hF0);
        chk("R5 pin_a", pin_a, 8'h03);
        @(negedge clk);
        for (int k = 0; k < 20; k++) issue(3'(k % 8), 8'(k * 37));
        repeat (3) @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    checks++; errors++;
                    $display("FAIL watchdog expired");
                end
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule